// File: doc/BRIEF.md
# Wait-State Memory Interface Controller

This block sits between a 32-bit host processor bus and a set of memory and peripheral regions. At the start of each processor-clock cycle it takes the host's request, address, read/write flag and byte/word flag. From address bits [22:20] it forms one-hot active-low chip selects for the external regions, or active-high selects for the two internal register regions. It also drives an active-low read strobe and four active-low byte write strobes. The block holds all of these for the whole bus cycle and releases them together at its end.

The block also generates the processor clock from the system clock, at half rate, with one system tick per phase. It stretches one chosen phase of that clock to insert wait states. The number of wait states depends on the region. For some regions it comes from a small wait-state register that the host writes through the support-function region, and values are clamped to legal ranges on write. Correlator accesses that follow another correlator access too closely receive extra wait states. A read from the ROM/flash region lengthens the following cycle by a fixed number of turnaround ticks, so that slow-releasing parts do not collide on the data bus.

Top module: `ws_mem_ctrl`

## Requirements
- R1: Address bits [22:20] select the region: 000 ROM (`cs_rom_no`), 001 RAM (`cs_ram_no`), 100 EEPROM (`cs_eep_no`), 101 spare (`cs_spare_no`), 010 correlator (`corr_sel_o`), 011 support (`sup_sel_o`). Codes 110 and 111, and cycles without `req_i`, select nothing. At most one select is active at a time.
- R2: `rd_no` is low exactly for read cycles to the four external regions. It never goes low together with a write strobe.
- R3: Write strobe `wr_no[i]` drives byte lane i. A word write to an external region drives all four strobes low. A byte write to RAM drives only the lane given by A[1:0] low. A byte write to ROM, EEPROM or spare behaves as a word write. Internal and unmapped cycles drive no strobe.
- R4: A cycle without wait states has one system tick of `mclk_o` low followed by one tick high. Each wait state adds two ticks to the low phase when `STRETCH_HIGH`=0, or to the high phase when it is 1. The turnaround ticks always go into the low phase.
- R5: RAM, unmapped, idle cycles, and support offsets with A[19:18]=11 take no wait state.
- R6: Support cycles with A[19:18] of 00 (real-time clock), 01 (dual UART) or 10 (system control) take exactly one wait state.
- R7: A correlator cycle takes one wait state. It takes `CORR_EXTRA_WS` more when fewer than `CORR_GAP_CYC` non-correlator processor cycles separate it from the previous correlator cycle.
- R8: ROM cycles take the ROM field of the wait-state register. EEPROM and spare cycles take its external field. After reset the fields hold 3 and 6.
- R9: A written ROM field below 1 is stored as 1. A written external field below 3 is stored as 3, and one above 6 is stored as 6.
- R10: The register is written by a support write with A[19:18]=10 and A[17:2] equal to `WSREG_IDX`. The data layout is ROM field `wdata_i[1:0]` and external field `wdata_i[4:2]`. The new value governs cycles that start after the write cycle. Writes to other offsets leave the register unchanged.
- R11: The cycle that follows a ROM read has `TURN_TICKS` extra low-phase ticks. No such ticks follow a ROM write or any other cycle.
- R12: Selects and strobes change only at the start of a processor cycle, which is the falling edge of `mclk_o`. During reset all of them are inactive and `mclk_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host requests a bus access in the next cycle |
| addr_i | input | 23 | Host address |
| write_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | 1 = byte access, 0 = word access |
| wdata_i | input | 5 | Low host write-data bits used by the wait-state register |
| mclk_o | output | 1 | Stretched processor clock |
| cs_rom_no | output | 1 | ROM/flash chip select, active low |
| cs_ram_no | output | 1 | RAM chip select, active low |
| cs_eep_no | output | 1 | EEPROM chip select, active low |
| cs_spare_no | output | 1 | Spare chip select, active low |
| corr_sel_o | output | 1 | Correlator register space selected |
| sup_sel_o | output | 1 | Support register space selected |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 4 | Byte write strobes, active low, bit i = lane i |

## Verification
The assertions relate only the block's own outputs to each other and to `mclk_o`, so they assume nothing about the host inputs. The design also samples those inputs only at a cycle boundary, so the assertions hold even if the inputs change in the middle of a cycle. The stimulus still behaves like a real host. It changes the request, address and flags only on the system tick right after a processor-cycle start, so each access is sampled whole and exactly once. Write data for the wait-state register is always driven in the legal 5-bit layout.

// File: rtl/ws_mem_pkg.sv
package ws_mem_pkg;

  typedef enum logic [2:0] {
    RG_ROM, RG_RAM, RG_CORR, RG_SUP, RG_EEP, RG_SPARE, RG_NONE
  } region_e;

  localparam int unsigned ROM_WS_MIN = 1;
  localparam int unsigned ROM_WS_MAX = 3;
  localparam int unsigned EXT_WS_MIN = 3;
  localparam int unsigned EXT_WS_MAX = 6;
  localparam int unsigned ROM_FLD_W  = 2;
  localparam int unsigned EXT_FLD_W  = 3;
  localparam int unsigned WSREG_W    = ROM_FLD_W + EXT_FLD_W;

  typedef struct packed {
    logic [3:0] cs_n;   // {spare, eep, ram, rom}
    logic       corr;
    logic       sup;
    logic       rd_n;
    logic [3:0] wr_n;
  } bus_out_t;

  localparam bus_out_t BUS_IDLE = '{cs_n: 4'hF, corr: 1'b0, sup: 1'b0,
                                    rd_n: 1'b1, wr_n: 4'hF};

endpackage

// File: rtl/ws_addr_decode.sv
module ws_addr_decode
  import ws_mem_pkg::*;
#(
  parameter int unsigned WSREG_IDX = 0
) (
  input  logic        req_i,
  input  logic [22:0] addr_i,
  input  logic        write_i,
  input  logic        byte_i,
  output region_e     region_o,
  output logic        sup_slow_o,
  output logic        wsreg_hit_o,
  output bus_out_t    bus_o
);

  logic ext;

  always_comb begin
    region_o = RG_NONE;
    if (req_i) begin
      unique case (addr_i[22:20])
        3'd0:    region_o = RG_ROM;
        3'd1:    region_o = RG_RAM;
        3'd2:    region_o = RG_CORR;
        3'd3:    region_o = RG_SUP;
        3'd4:    region_o = RG_EEP;
        3'd5:    region_o = RG_SPARE;
        default: region_o = RG_NONE;
      endcase
    end
  end

  always_comb begin
    bus_o = BUS_IDLE;
    ext   = 1'b0;
    unique case (region_o)
      RG_ROM:   begin bus_o.cs_n[0] = 1'b0; ext = 1'b1; end
      RG_RAM:   begin bus_o.cs_n[1] = 1'b0; ext = 1'b1; end
      RG_EEP:   begin bus_o.cs_n[2] = 1'b0; ext = 1'b1; end
      RG_SPARE: begin bus_o.cs_n[3] = 1'b0; ext = 1'b1; end
      RG_CORR:  bus_o.corr = 1'b1;
      RG_SUP:   bus_o.sup  = 1'b1;
      default:  ;
    endcase
    bus_o.rd_n = ~(ext & ~write_i);
    if (ext && write_i) begin
      // byte lanes only reach RAM; other parts take whole words
      if (byte_i && region_o == RG_RAM) bus_o.wr_n[addr_i[1:0]] = 1'b0;
      else                              bus_o.wr_n = 4'h0;
    end
  end

  assign sup_slow_o  = (region_o == RG_SUP) && (addr_i[19:18] != 2'b11);
  assign wsreg_hit_o = (region_o == RG_SUP) && write_i &&
                       (addr_i[19:18] == 2'b10) &&
                       (addr_i[17:2] == 16'(WSREG_IDX));

endmodule

// File: rtl/ws_wait_reg.sv
module ws_wait_reg
  import ws_mem_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [WSREG_W-1:0]   wdata_i,
  output logic [ROM_FLD_W-1:0] rom_ws_o,
  output logic [EXT_FLD_W-1:0] ext_ws_o
);

  function automatic logic [ROM_FLD_W-1:0] clamp_rom(input logic [ROM_FLD_W-1:0] v);
    if (v < ROM_FLD_W'(ROM_WS_MIN)) return ROM_FLD_W'(ROM_WS_MIN);
    if (v > ROM_FLD_W'(ROM_WS_MAX)) return ROM_FLD_W'(ROM_WS_MAX);
    return v;
  endfunction

  function automatic logic [EXT_FLD_W-1:0] clamp_ext(input logic [EXT_FLD_W-1:0] v);
    if (v < EXT_FLD_W'(EXT_WS_MIN)) return EXT_FLD_W'(EXT_WS_MIN);
    if (v > EXT_FLD_W'(EXT_WS_MAX)) return EXT_FLD_W'(EXT_WS_MAX);
    return v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_ws_o <= ROM_FLD_W'(ROM_WS_MAX);
      ext_ws_o <= EXT_FLD_W'(EXT_WS_MAX);
    end else if (we_i) begin
      rom_ws_o <= clamp_rom(wdata_i[ROM_FLD_W-1:0]);
      ext_ws_o <= clamp_ext(wdata_i[WSREG_W-1:ROM_FLD_W]);
    end
  end

endmodule

// File: rtl/ws_wait_calc.sv
module ws_wait_calc
  import ws_mem_pkg::*;
#(
  parameter int unsigned CORR_EXTRA_WS = 3,
  parameter int unsigned WS_W          = 3
) (
  input  region_e              region_i,
  input  logic                 sup_slow_i,
  input  logic                 corr_close_i,
  input  logic [ROM_FLD_W-1:0] rom_ws_i,
  input  logic [EXT_FLD_W-1:0] ext_ws_i,
  output logic [WS_W-1:0]      ws_o
);

  localparam logic [WS_W-1:0] WS_ONE   = WS_W'(1);
  localparam logic [WS_W-1:0] WS_EXTRA = WS_W'(CORR_EXTRA_WS);

  always_comb begin
    unique case (region_i)
      RG_ROM:           ws_o = WS_W'(rom_ws_i);
      RG_EEP, RG_SPARE: ws_o = WS_W'(ext_ws_i);
      RG_CORR:          ws_o = corr_close_i ? WS_ONE + WS_EXTRA : WS_ONE;
      RG_SUP:           ws_o = sup_slow_i ? WS_ONE : '0;
      default:          ws_o = '0;
    endcase
  end

endmodule

// File: rtl/ws_clk_stretch.sv
module ws_clk_stretch #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] low_len_i,
  input  logic [CNT_W-1:0] high_len_i,
  output logic             mclk_o,
  output logic             cyc_end_o
);

  logic             phase_q;   // 0 low, 1 high
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hi_len_q;

  assign cyc_end_o = phase_q && (cnt_q == '0);
  assign mclk_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b1;
      cnt_q    <= '0;
      hi_len_q <= CNT_W'(1);
    end else if (cyc_end_o) begin
      phase_q  <= 1'b0;
      cnt_q    <= low_len_i - CNT_W'(1);
      hi_len_q <= high_len_i;
    end else if (cnt_q == '0) begin
      phase_q  <= 1'b1;
      cnt_q    <= hi_len_q - CNT_W'(1);
    end else begin
      cnt_q    <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/ws_mem_ctrl.sv
module ws_mem_ctrl
  import ws_mem_pkg::*;
#(
  parameter bit          STRETCH_HIGH  = 1'b0,
  parameter int unsigned TURN_TICKS    = 2,
  parameter int unsigned CORR_GAP_CYC  = 2,
  parameter int unsigned CORR_EXTRA_WS = 3,
  parameter int unsigned WSREG_IDX     = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic [22:0] addr_i,
  input  logic        write_i,
  input  logic        byte_i,
  input  logic [4:0]  wdata_i,
  output logic        mclk_o,
  output logic        cs_rom_no,
  output logic        cs_ram_no,
  output logic        cs_eep_no,
  output logic        cs_spare_no,
  output logic        corr_sel_o,
  output logic        sup_sel_o,
  output logic        rd_no,
  output logic [3:0]  wr_no
);

  localparam int unsigned CORR_MAX_WS = 1 + CORR_EXTRA_WS;
  localparam int unsigned MAX_WS = (CORR_MAX_WS > EXT_WS_MAX) ? CORR_MAX_WS : EXT_WS_MAX;
  localparam int unsigned WS_W   = $clog2(MAX_WS + 1);
  localparam int unsigned CNT_W  = $clog2(2 * MAX_WS + TURN_TICKS + 2);
  localparam int unsigned GAP_W  = $clog2(CORR_GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(CORR_GAP_CYC);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TURN_C  = CNT_W'(TURN_TICKS);

  region_e              dec_region;
  logic                 dec_sup_slow;
  logic                 dec_wsreg_hit;
  bus_out_t             dec_bus;
  logic [ROM_FLD_W-1:0] rom_ws;
  logic [EXT_FLD_W-1:0] ext_ws;
  logic [WS_W-1:0]      ws;
  logic                 cyc_end;
  logic                 corr_close;
  logic [GAP_W-1:0]     sep;
  logic [CNT_W-1:0]     ws_ticks, turn_add, low_len, high_len;

  bus_out_t             bus_q;
  logic                 turn_q;
  logic [GAP_W-1:0]     gap_q;

  ws_addr_decode #(.WSREG_IDX(WSREG_IDX)) u_dec (
    .req_i      (req_i),
    .addr_i     (addr_i),
    .write_i    (write_i),
    .byte_i     (byte_i),
    .region_o   (dec_region),
    .sup_slow_o (dec_sup_slow),
    .wsreg_hit_o(dec_wsreg_hit),
    .bus_o      (dec_bus)
  );

  ws_wait_reg u_wreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cyc_end && dec_wsreg_hit),
    .wdata_i (wdata_i),
    .rom_ws_o(rom_ws),
    .ext_ws_o(ext_ws)
  );

  // separation in processor cycles since the last correlator cycle
  always_comb begin
    if (bus_q.corr)          sep = '0;
    else if (gap_q >= GAP_LIM) sep = GAP_LIM;
    else                     sep = gap_q + GAP_W'(1);
  end
  assign corr_close = (dec_region == RG_CORR) && (sep < GAP_LIM);

  ws_wait_calc #(.CORR_EXTRA_WS(CORR_EXTRA_WS), .WS_W(WS_W)) u_calc (
    .region_i    (dec_region),
    .sup_slow_i  (dec_sup_slow),
    .corr_close_i(corr_close),
    .rom_ws_i    (rom_ws),
    .ext_ws_i    (ext_ws),
    .ws_o        (ws)
  );

  assign ws_ticks = CNT_W'({ws, 1'b0});
  assign turn_add = turn_q ? TURN_C : '0;

  generate
    if (STRETCH_HIGH) begin : g_stretch_high
      assign low_len  = ONE_C + turn_add;
      assign high_len = ONE_C + ws_ticks;
    end else begin : g_stretch_low
      assign low_len  = ONE_C + ws_ticks + turn_add;
      assign high_len = ONE_C;
    end
  endgenerate

  ws_clk_stretch #(.CNT_W(CNT_W)) u_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .low_len_i (low_len),
    .high_len_i(high_len),
    .mclk_o    (mclk_o),
    .cyc_end_o (cyc_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_q  <= BUS_IDLE;
      turn_q <= 1'b0;
      gap_q  <= GAP_LIM;
    end else if (cyc_end) begin
      bus_q  <= dec_bus;
      turn_q <= (dec_region == RG_ROM) && !write_i;
      gap_q  <= sep;
    end
  end

  assign cs_rom_no   = bus_q.cs_n[0];
  assign cs_ram_no   = bus_q.cs_n[1];
  assign cs_eep_no   = bus_q.cs_n[2];
  assign cs_spare_no = bus_q.cs_n[3];
  assign corr_sel_o  = bus_q.corr;
  assign sup_sel_o   = bus_q.sup;
  assign rd_no       = bus_q.rd_n;
  assign wr_no       = bus_q.wr_n;

endmodule

// File: rtl/ws_mem_ctrl_chk.sv
module ws_mem_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mclk_o,
  input logic       cs_rom_no,
  input logic       cs_ram_no,
  input logic       cs_eep_no,
  input logic       cs_spare_no,
  input logic       corr_sel_o,
  input logic       sup_sel_o,
  input logic       rd_no,
  input logic [3:0] wr_no
);

  logic [3:0] ext_sel;
  assign ext_sel = ~{cs_spare_no, cs_eep_no, cs_ram_no, cs_rom_no};

  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ext_sel, corr_sel_o, sup_sel_o}));

  assert_rd_no_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (wr_no == 4'hF));

  assert_rd_ext_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (ext_sel != 4'h0));

  assert_wr_needs_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_no != 4'hF) |-> (ext_sel != 4'h0));

  assert_byte_ram_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_no != 4'hF && wr_no != 4'h0) |-> (!cs_ram_no && $countones(wr_no) == 3));

  assert_hold_in_cycle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(mclk_o) |-> $stable({ext_sel, corr_sel_o, sup_sel_o, rd_no, wr_no}));

endmodule

bind ws_mem_ctrl ws_mem_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mclk_o     (mclk_o),
  .cs_rom_no  (cs_rom_no),
  .cs_ram_no  (cs_ram_no),
  .cs_eep_no  (cs_eep_no),
  .cs_spare_no(cs_spare_no),
  .corr_sel_o (corr_sel_o),
  .sup_sel_o  (sup_sel_o),
  .rd_no      (rd_no),
  .wr_no      (wr_no)
);

// File: tb/ws_mem_ctrl_tb_top.sv
`timescale 1ns/1ps
module ws_mem_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic [22:0] addr = '0;
  logic        wr = 1'b0;
  logic        bt = 1'b0;
  logic [4:0]  wdata = '0;
  logic        mclk_o, cs_rom_no, cs_ram_no, cs_eep_no, cs_spare_no;
  logic        corr_sel_o, sup_sel_o, rd_no;
  logic [3:0]  wr_no;

  always #10 clk = ~clk;  // 50 MHz

  ws_mem_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr), .write_i(wr),
    .byte_i(bt), .wdata_i(wdata), .mclk_o(mclk_o), .cs_rom_no(cs_rom_no),
    .cs_ram_no(cs_ram_no), .cs_eep_no(cs_eep_no), .cs_spare_no(cs_spare_no),
    .corr_sel_o(corr_sel_o), .sup_sel_o(sup_sel_o), .rd_no(rd_no), .wr_no(wr_no)
  );

  typedef struct {
    logic [10:0] outs;  // {cs_n[3:0] spare..rom, sup, corr, rd_n, wr_n[3:0]}
    int          len;
    string       tag;
  } exp_t;

  localparam logic [3:0] CS_N = 4'b1111, CS_ROM = 4'b1110, CS_RAM = 4'b1101,
                         CS_EEP = 4'b1011, CS_SPR = 4'b0111;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;
  logic mclk_d = 1'b1;
  logic cyc_start;

  always @(posedge clk) mclk_d <= mclk_o;
  assign cyc_start = mclk_d & ~mclk_o;

  function automatic logic [10:0] act_outs();
    return {cs_spare_no, cs_eep_no, cs_ram_no, cs_rom_no, sup_sel_o, corr_sel_o, rd_no, wr_no};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // monitor: one expected item per processor cycle
  initial begin
    exp_t cur;
    bit have = 0, unstable = 0;
    int len_cnt = 0, low_cnt = 0;
    logic [10:0] snap = '0;
    @(posedge rst_ni);
    forever begin
      @(negedge clk);
      if (cyc_start) begin
        if (have) begin
          chk(len_cnt == cur.len && low_cnt == cur.len - 1,
              {cur.tag, " R4 cycle ticks"}, {16'(len_cnt), 16'(low_cnt)},
              {16'(cur.len), 16'(cur.len - 1)});
          chk(!unstable, {cur.tag, " R12 hold"}, 32'(unstable), 32'd0);
        end
        have = (q.size() != 0);
        if (have) begin
          cur = q.pop_front();
          chk(act_outs() == cur.outs, {cur.tag, " outputs"}, 32'(act_outs()), 32'(cur.outs));
        end
        snap = act_outs();
        len_cnt = 1; low_cnt = 1; unstable = 0;
      end else begin
        len_cnt++;
        if (!mclk_o) low_cnt++;
        if (act_outs() != snap) unstable = 1;
      end
    end
  end

  // driver: presents the access for the next cycle right after a cycle start
  task automatic acc(input logic r, input logic [22:0] a, input logic w, input logic b,
                     input logic [4:0] d, input logic [3:0] ecs, input logic [1:0] esel,
                     input logic erd, input logic [3:0] ewr, input int elen, input string tag);
    exp_t e;
    @(negedge clk);
    while (!cyc_start) @(negedge clk);
    req = r; addr = a; wr = w; bt = b; wdata = d;
    e.outs = {ecs, esel, erd, ewr};
    e.len = elen;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    acc(1'b0, 23'h0, 1'b0, 1'b0, 5'h0, CS_N, 2'b00, 1'b1, 4'hF, 2, tag);
  endtask

  initial begin
    exp_t e0;
    repeat (3) @(negedge clk);
    chk({mclk_o, act_outs()} == {1'b1, CS_N, 2'b00, 1'b1, 4'hF},
        "R12 reset state", 32'({mclk_o, act_outs()}), 32'({1'b1, CS_N, 2'b00, 1'b1, 4'hF}));
    e0.outs = {CS_N, 2'b00, 1'b1, 4'hF}; e0.len = 2; e0.tag = "R4 R5 first idle";
    q.push_back(e0);
    rst_ni = 1'b1;

    acc(1, 23'h100010, 0, 0, 0, CS_RAM, 2'b00, 0, 4'hF, 2, "R1 R2 R5 ram read");
    acc(1, 23'h100010, 1, 0, 0, CS_RAM, 2'b00, 1, 4'h0, 2, "R3 ram word write");
    acc(1, 23'h100002, 1, 1, 0, CS_RAM, 2'b00, 1, 4'b1011, 2, "R3 ram byte lane2");
    acc(1, 23'h100003, 1, 1, 0, CS_RAM, 2'b00, 1, 4'b0111, 2, "R3 ram byte lane3");
    acc(1, 23'h000040, 0, 0, 0, CS_ROM, 2'b00, 0, 4'hF, 8, "R8 rom read reset ws");
    acc(1, 23'h100000, 0, 0, 0, CS_RAM, 2'b00, 0, 4'hF, 4, "R11 turnaround after rom read");
    acc(1, 23'h000000, 1, 1, 0, CS_ROM, 2'b00, 1, 4'h0, 8, "R3 rom byte flag as word");
    idle("R11 no turnaround after rom write");
    acc(1, 23'h400000, 0, 0, 0, CS_EEP, 2'b00, 0, 4'hF, 14, "R8 eeprom read reset ws");
    acc(1, 23'h500001, 1, 1, 0, CS_SPR, 2'b00, 1, 4'h0, 14, "R3 R8 spare byte write");
    acc(1, 23'h200000, 0, 0, 0, CS_N, 2'b01, 1, 4'hF, 4, "R7 corr spaced");
    acc(1, 23'h200001, 1, 1, 0, CS_N, 2'b01, 1, 4'hF, 10, "R7 corr back to back");
    idle("R5 idle");
    acc(1, 23'h200000, 0, 0, 0, CS_N, 2'b01, 1, 4'hF, 10, "R7 corr one cycle gap");
    idle("R5 idle");
    idle("R5 idle");
    acc(1, 23'h200000, 0, 0, 0, CS_N, 2'b01, 1, 4'hF, 4, "R7 corr two cycle gap");
    acc(1, 23'h300000, 0, 0, 0, CS_N, 2'b10, 1, 4'hF, 4, "R6 support rtc");
    acc(1, 23'h340008, 1, 0, 0, CS_N, 2'b10, 1, 4'hF, 4, "R6 support uart write");
    acc(1, 23'h3C0000, 0, 0, 0, CS_N, 2'b10, 1, 4'hF, 2, "R5 support reserved");
    acc(1, 23'h600000, 0, 0, 0, CS_N, 2'b00, 1, 4'hF, 2, "R1 unmapped 110 read");
    acc(1, 23'h700000, 1, 0, 0, CS_N, 2'b00, 1, 4'hF, 2, "R1 unmapped 111 write");
    acc(1, 23'h380000, 1, 0, 5'b001_00, CS_N, 2'b10, 1, 4'hF, 4, "R10 wsreg write low");
    acc(1, 23'h000000, 0, 0, 0, CS_ROM, 2'b00, 0, 4'hF, 4, "R9 rom clamped to 1");
    acc(1, 23'h400000, 0, 0, 0, CS_EEP, 2'b00, 0, 4'hF, 10, "R9 R11 eeprom clamped to 3");
    acc(1, 23'h380000, 1, 0, 5'b111_10, CS_N, 2'b10, 1, 4'hF, 4, "R10 wsreg write high");
    acc(1, 23'h380004, 1, 0, 5'b000_00, CS_N, 2'b10, 1, 4'hF, 4, "R10 other sysctl write");
    acc(1, 23'h000000, 0, 0, 0, CS_ROM, 2'b00, 0, 4'hF, 6, "R8 R10 rom ws 2 kept");
    acc(1, 23'h000004, 0, 0, 0, CS_ROM, 2'b00, 0, 4'hF, 8, "R11 rom after rom read");
    acc(1, 23'h500000, 1, 0, 0, CS_SPR, 2'b00, 1, 4'h0, 16, "R9 R11 spare clamped to 6");
    idle("R4 idle");
    idle("R4 final idle");

    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    while (!cyc_start) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog R12 act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule